// File: doc/BRIEF.md
# Two-Port Word Memory with Mailbox Interrupts

This block is a synchronous memory with two independent ports, left and right. Each port can read or write any word on any clock. Each port has two byte-lane enables, one for the upper byte and one for the lower byte. Read data is registered. With the default parameters the memory holds 2048 words of 16 bits. With `ADDR_W = 13` it holds 8192 words, and the two mailbox words then sit at 0x1FFE and 0x1FFF.

The two highest addresses also act as mailboxes when the mailbox function is enabled. The word at address DEPTH-2 belongs to the left port and the word at DEPTH-1 belongs to the right port. When one port writes the mailbox word owned by the other port, that other port's active-low interrupt is raised. The interrupt clears when the owning port reads its own mailbox. The mailbox words hold ordinary user data. When `mbox_en` is low they are plain storage and no interrupt is ever produced.

Each interrupt flag is a two-state machine with the states MB_IDLE and MB_PENDING. It uses the following transitions:
- set: MB_IDLE to MB_PENDING, when the peer writes the mailbox while the function is enabled.
- clear: MB_PENDING to MB_IDLE, when the owner reads the mailbox and there is no set in the same cycle.
- drop: MB_PENDING to MB_IDLE, when `mbox_en` is low.
- hold: the state stays as it is in every other case.

Each port decoder sorts every cycle into one of three access kinds: ACC_IDLE, ACC_READ or ACC_WRITE.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: A word written through either port, with both lanes enabled, is returned unchanged by a later read from either port.
- R2: On a write, only the lanes whose enable is high are changed; `*_ben_hi` selects bits 15:8 and `*_ben_lo` selects bits 7:0. On a read, any lane whose enable is low returns zero.
- R3: A read cycle has `sel`=1, `wr`=0 and `oe`=1, and its data appears on `rdata` in the next cycle. After any other cycle `rdata` is all zero. A cycle with `sel`=0 changes no memory.
- R4: When both ports write the same lane of the same address in one cycle, the left port's data is stored. A read of a word that the other port writes in the same cycle returns the old contents.
- R5: While `mbox_en`=1, if the right port writes address DEPTH-2 with at least one lane enabled, `l_irq_n` is low from the next cycle.
- R6: When the left port reads address DEPTH-2 (`sel`=1, `wr`=0, whatever `oe` and the lanes are), a pending left interrupt clears in the next cycle.
- R7: The right interrupt works the same way as R5 and R6. The left port's write of DEPTH-1 sets `r_irq_n` low, and the right port's read of DEPTH-1 clears it.
- R8: A set and a clear of the same interrupt in the same cycle leave the interrupt set.
- R9: A port writing its own mailbox, or reading the peer's mailbox, has no effect on either interrupt.
- R10: While `mbox_en`=0, no interrupt is raised and a pending interrupt is dropped in the next cycle. The mailbox words still store data as ordinary words.
- R11: During and after reset both `irq_n` outputs are high and both `rdata` buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbox_en | input | 1 | Enables the mailbox interrupts |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_ben_hi | input | 1 | Left upper-lane enable |
| l_ben_lo | input | 1 | Left lower-lane enable |
| l_rdata | output | 2*LANE_W | Left read data |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_ben_hi | input | 1 | Right upper-lane enable |
| r_ben_lo | input | 1 | Right lower-lane enable |
| r_rdata | output | 2*LANE_W | Right read data |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The hardest case to reach is the one where a set and a clear land on the same flag in the same cycle. For that, the owner's read of its mailbox must line up exactly with the peer's write of that mailbox. Same-lane write collisions and read-during-write on one word are just as narrow. The directed phases drive both ports in one cycle to make each of these coincidences deliberately. A random phase then confines both ports to ten addresses, including the two mailbox words, so that collisions, mailbox hits and enable toggles occur often. Every clock is compared against a behavioural model.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // Kind of access a port performs in one cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Mailbox flag state
    typedef enum logic {
        MB_IDLE    = 1'b0,
        MB_PENDING = 1'b1
    } mb_state_e;

endpackage

// File: rtl/dpm_lane_ram.sv
module dpm_lane_ram #(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LANE_W-1:0] a_wd,
    output logic [LANE_W-1:0] a_q,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [LANE_W-1:0] b_wd,
    output logic [LANE_W-1:0] b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // Port a is written last, so it wins a same-address collision.
    // Reads see the contents from before this edge.
    always_ff @(posedge clk) begin
        if (b_we) begin
            mem[b_addr] <= b_wd;
        end
        if (a_we) begin
            mem[a_addr] <= a_wd;
        end
        if (a_re) begin
            a_q <= mem[a_addr];
        end
        if (b_re) begin
            b_q <= mem[b_addr];
        end
    end
endmodule

// File: rtl/dpm_port_ctl.sv
module dpm_port_ctl
    import dpm_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic             oe,
    input  logic [LANES-1:0] lane_sel,
    output acc_kind_e        kind,
    output logic [LANES-1:0] lane_we,
    output logic [LANES-1:0] lane_re,
    output logic [LANES-1:0] rd_mask_q
);
    logic rd_en;

    // Classify the access. A write with no lane enabled is no access.
    always_comb begin
        kind = ACC_IDLE;
        if (sel) begin
            if (!wr) begin
                kind = ACC_READ;
            end else if (|lane_sel) begin
                kind = ACC_WRITE;
            end
        end
    end

    // Strobes into the lane memories
    always_comb begin
        lane_we = '0;
        rd_en   = 1'b0;
        unique case (kind)
            ACC_WRITE: lane_we = lane_sel;
            ACC_READ:  rd_en   = oe;
            default:   lane_we = '0;
        endcase
        lane_re = rd_en ? lane_sel : '0;
    end

    // Registered lane mask: which lanes drive read data in the next cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_mask_q <= '0;
        end else begin
            rd_mask_q <= lane_re;
        end
    end
endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    mb_state_e state_q;
    mb_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: a set wins over a clear, and disable drops the flag
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_IDLE: begin
                if (enable && set_req) begin
                    state_d = MB_PENDING;
                end
            end
            MB_PENDING: begin
                if (!enable) begin
                    state_d = MB_IDLE;
                end else if (set_req) begin
                    state_d = MB_PENDING;
                end else if (clr_req) begin
                    state_d = MB_IDLE;
                end
            end
            default: state_d = MB_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        irq_n = (state_q != MB_PENDING);
    end
endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mbox_en,
    input  logic                  l_sel,
    input  logic                  l_wr,
    input  logic                  l_oe,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [2*LANE_W-1:0]   l_wdata,
    input  logic                  l_ben_hi,
    input  logic                  l_ben_lo,
    output logic [2*LANE_W-1:0]   l_rdata,
    output logic                  l_irq_n,
    input  logic                  r_sel,
    input  logic                  r_wr,
    input  logic                  r_oe,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [2*LANE_W-1:0]   r_wdata,
    input  logic                  r_ben_hi,
    input  logic                  r_ben_lo,
    output logic [2*LANE_W-1:0]   r_rdata,
    output logic                  r_irq_n
);
    localparam int LANES = 2;
    localparam logic [ADDR_W-1:0] MBOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] MBOX_R = {ADDR_W{1'b1}};

    acc_kind_e        l_kind, r_kind;
    logic [LANES-1:0] l_lane_we, r_lane_we;
    logic [LANES-1:0] l_lane_re, r_lane_re;
    logic [LANES-1:0] l_mask_q, r_mask_q;
    logic [LANE_W-1:0] l_q [LANES];
    logic [LANE_W-1:0] r_q [LANES];

    dpm_port_ctl #(.LANES(LANES)) u_lctl (
        .clk(clk), .rst_n(rst_n),
        .sel(l_sel), .wr(l_wr), .oe(l_oe),
        .lane_sel({l_ben_hi, l_ben_lo}),
        .kind(l_kind), .lane_we(l_lane_we), .lane_re(l_lane_re),
        .rd_mask_q(l_mask_q)
    );

    dpm_port_ctl #(.LANES(LANES)) u_rctl (
        .clk(clk), .rst_n(rst_n),
        .sel(r_sel), .wr(r_wr), .oe(r_oe),
        .lane_sel({r_ben_hi, r_ben_lo}),
        .kind(r_kind), .lane_we(r_lane_we), .lane_re(r_lane_re),
        .rd_mask_q(r_mask_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpm_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
            .clk(clk),
            .a_we(l_lane_we[g]), .a_re(l_lane_re[g]), .a_addr(l_addr),
            .a_wd(l_wdata[g*LANE_W +: LANE_W]), .a_q(l_q[g]),
            .b_we(r_lane_we[g]), .b_re(r_lane_re[g]), .b_addr(r_addr),
            .b_wd(r_wdata[g*LANE_W +: LANE_W]), .b_q(r_q[g])
        );
        assign l_rdata[g*LANE_W +: LANE_W] = l_mask_q[g] ? l_q[g] : '0;
        assign r_rdata[g*LANE_W +: LANE_W] = r_mask_q[g] ? r_q[g] : '0;
    end

    // Mailbox decode: peer writes set, owner reads clear
    logic l_set, l_clr, r_set, r_clr;
    always_comb begin
        l_set = mbox_en && (r_kind == ACC_WRITE) && (r_addr == MBOX_L);
        l_clr = (l_kind == ACC_READ) && (l_addr == MBOX_L);
        r_set = mbox_en && (l_kind == ACC_WRITE) && (l_addr == MBOX_R);
        r_clr = (r_kind == ACC_READ) && (r_addr == MBOX_R);
    end

    dpm_mbox_flag u_lflag (
        .clk(clk), .rst_n(rst_n), .enable(mbox_en),
        .set_req(l_set), .clr_req(l_clr), .irq_n(l_irq_n)
    );

    dpm_mbox_flag u_rflag (
        .clk(clk), .rst_n(rst_n), .enable(mbox_en),
        .set_req(r_set), .clr_req(r_clr), .irq_n(r_irq_n)
    );
endmodule

// File: rtl/dpm_mailbox_ram_chk.sv
module dpm_mailbox_ram_chk #(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mbox_en,
    input logic                l_sel,
    input logic                l_wr,
    input logic                l_oe,
    input logic [ADDR_W-1:0]   l_addr,
    input logic                l_ben_hi,
    input logic                l_ben_lo,
    input logic [2*LANE_W-1:0] l_rdata,
    input logic                l_irq_n,
    input logic                r_sel,
    input logic                r_wr,
    input logic                r_oe,
    input logic [ADDR_W-1:0]   r_addr,
    input logic                r_ben_hi,
    input logic                r_ben_lo,
    input logic [2*LANE_W-1:0] r_rdata,
    input logic                r_irq_n
);
    localparam logic [ADDR_W-1:0] MB_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] MB_R = {ADDR_W{1'b1}};

    logic r_hits_l, l_hits_r, l_reads_own, r_reads_own;
    assign r_hits_l    = r_sel && r_wr && (r_ben_hi || r_ben_lo) && (r_addr == MB_L);
    assign l_hits_r    = l_sel && l_wr && (l_ben_hi || l_ben_lo) && (l_addr == MB_R);
    assign l_reads_own = l_sel && !l_wr && (l_addr == MB_L);
    assign r_reads_own = r_sel && !r_wr && (r_addr == MB_R);

    AST_LEFT_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && r_hits_l) |=> !l_irq_n); // R5
    AST_LEFT_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && l_reads_own && !r_hits_l) |=> l_irq_n); // R6
    AST_RIGHT_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && l_hits_r) |=> !r_irq_n); // R7
    AST_RIGHT_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && r_reads_own && !l_hits_r) |=> r_irq_n); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && r_hits_l && l_reads_own) |=> !l_irq_n); // R8
    AST_NO_STRAY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !(mbox_en && r_hits_l)) |=> l_irq_n); // R9
    AST_NO_STRAY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !(mbox_en && l_hits_r)) |=> r_irq_n); // R9
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_en |=> (l_irq_n && r_irq_n)); // R10
    AST_LEFT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_sel && !l_wr && l_oe) |=> (l_rdata == '0)); // R3
    AST_RIGHT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_sel && !r_wr && r_oe) |=> (r_rdata == '0)); // R3
    AST_LANE_GATE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !l_ben_hi |=> (l_rdata[2*LANE_W-1:LANE_W] == '0)); // R2
    AST_LANE_GATE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !r_ben_lo |=> (r_rdata[LANE_W-1:0] == '0)); // R2
endmodule

bind dpm_mailbox_ram dpm_mailbox_ram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
    .l_ben_hi(l_ben_hi), .l_ben_lo(l_ben_lo), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
    .r_ben_hi(r_ben_hi), .r_ben_lo(r_ben_lo), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
);

// File: tb/dpm_mailbox_ram_tb.sv
module dpm_mailbox_ram_tb;
    localparam int AW = 11;
    localparam int LW = 8;
    localparam int DW = 2 * LW;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] MB_L = AW'(DEPTH - 2);
    localparam logic [AW-1:0] MB_R = AW'(DEPTH - 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, mbox_en;
    logic l_sel, l_wr, l_oe, l_ben_hi, l_ben_lo, l_irq_n;
    logic r_sel, r_wr, r_oe, r_ben_hi, r_ben_lo, r_irq_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    dpm_mailbox_ram #(.ADDR_W(AW), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_ben_hi(l_ben_hi), .l_ben_lo(l_ben_lo), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_ben_hi(r_ben_hi), .r_ben_lo(r_ben_lo), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    // Behavioural reference state
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] exp_lrd, exp_rrd;
    bit exp_lirq, exp_rirq;
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_req = "R11";

    function automatic logic [DW-1:0] lmask(input logic hi, input logic lo);
        return {{LW{hi}}, {LW{lo}}};
    endfunction

    function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return 'x;
    endfunction

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [DW-1:0] m;
        bit set_l, clr_l, set_r, clr_r;
        if (!rst_n) begin
            exp_lrd = '0; exp_rrd = '0; exp_lirq = 0; exp_rirq = 0;
            return;
        end
        // reads see contents before this edge
        m = lmask(l_ben_hi, l_ben_lo);
        exp_lrd = (l_sel && !l_wr && l_oe) ? (peek(l_addr) & m) : '0;
        m = lmask(r_ben_hi, r_ben_lo);
        exp_rrd = (r_sel && !r_wr && r_oe) ? (peek(r_addr) & m) : '0;
        // interrupt flags (active-high pending in the model)
        set_l = mbox_en && r_sel && r_wr && (r_ben_hi || r_ben_lo) && r_addr == MB_L;
        clr_l = l_sel && !l_wr && l_addr == MB_L;
        set_r = mbox_en && l_sel && l_wr && (l_ben_hi || l_ben_lo) && l_addr == MB_R;
        clr_r = r_sel && !r_wr && r_addr == MB_R;
        exp_lirq = !mbox_en ? 0 : set_l ? 1 : clr_l ? 0 : exp_lirq;
        exp_rirq = !mbox_en ? 0 : set_r ? 1 : clr_r ? 0 : exp_rirq;
        // writes: right first, then left, so left wins a collision
        if (r_sel && r_wr) begin
            m = lmask(r_ben_hi, r_ben_lo);
            ref_mem[int'(r_addr)] = (peek(r_addr) & ~m) | (r_wdata & m);
        end
        if (l_sel && l_wr) begin
            m = lmask(l_ben_hi, l_ben_lo);
            ref_mem[int'(l_addr)] = (peek(l_addr) & ~m) | (l_wdata & m);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!$isunknown(exp_lrd)) chk("l_rdata", l_rdata, exp_lrd);
        if (!$isunknown(exp_rrd)) chk("r_rdata", r_rdata, exp_rrd);
        chk("l_irq_n", DW'(l_irq_n), DW'(!exp_lirq));
        chk("r_irq_n", DW'(r_irq_n), DW'(!exp_rirq));
    endtask

    task automatic lset(input logic s, input logic w, input logic o, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic h, input logic lo);
        l_sel = s; l_wr = w; l_oe = o; l_addr = a; l_wdata = d; l_ben_hi = h; l_ben_lo = lo;
    endtask

    task automatic rset(input logic s, input logic w, input logic o, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic h, input logic lo);
        r_sel = s; r_wr = w; r_oe = o; r_addr = a; r_wdata = d; r_ben_hi = h; r_ben_lo = lo;
    endtask

    task automatic idle();
        lset(0, 0, 0, '0, '0, 0, 0);
        rset(0, 0, 0, '0, '0, 0, 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL %s watchdog: actual %0d cycles expected fewer than 100000", cur_req, cyc);
            finish_run();
        end
    end

    initial begin
        rst_n = 0; mbox_en = 1;
        idle();
        // R11: reset state
        step(); step();
        chk("l_rdata reset", l_rdata, '0);
        chk("r_rdata reset", r_rdata, '0);
        chk("irq reset", DW'({l_irq_n, r_irq_n}), DW'(2'b11));
        @(negedge clk); rst_n = 1;
        step();

        // R1: fill from each side, read back from the other
        cur_req = "R1";
        for (int i = 0; i < 16; i++) begin
            lset(1, 1, 0, AW'(i), DW'(16'h1000 + i * 16'h0111), 1, 1);
            rset(1, 1, 0, AW'(100 + i), DW'(16'hC3A0 ^ i), 1, 1);
            step();
        end
        for (int i = 0; i < 16; i++) begin
            rset(1, 0, 1, AW'(i), '0, 1, 1);
            lset(1, 0, 1, AW'(100 + i), '0, 1, 1);
            step();
        end
        idle(); step();

        // R2: byte lanes on write and read
        cur_req = "R2";
        lset(1, 1, 0, AW'(200), 16'hA5C3, 1, 1); step();
        idle(); rset(1, 1, 0, AW'(200), 16'h7711, 0, 1); step();
        idle(); lset(1, 0, 1, AW'(200), '0, 1, 1); step();   // expect A511
        lset(1, 0, 1, AW'(200), '0, 1, 0); step();          // expect A500
        lset(1, 0, 1, AW'(200), '0, 0, 1); step();          // expect 0011
        idle(); step();

        // R3: output enable low, deselected write
        cur_req = "R3";
        lset(1, 0, 0, AW'(200), '0, 1, 1); step();
        idle(); rset(0, 1, 0, AW'(200), 16'hFFFF, 1, 1); step();
        idle(); rset(1, 0, 1, AW'(200), '0, 1, 1); step();
        idle(); step();

        // R4: same-address collision, read during other port's write
        cur_req = "R4";
        lset(1, 1, 0, AW'(300), 16'h1111, 1, 1);
        rset(1, 1, 0, AW'(300), 16'h2222, 1, 1); step();
        lset(1, 1, 0, AW'(300), 16'h3300, 1, 0);
        rset(1, 1, 0, AW'(300), 16'h4444, 1, 1); step();     // expect 3344
        lset(1, 0, 1, AW'(300), '0, 1, 1);
        rset(1, 1, 0, AW'(300), 16'h5555, 1, 1); step();     // left sees 3344
        idle(); lset(1, 0, 1, AW'(300), '0, 1, 1); step();
        idle(); step();

        // R5 / R6: left mailbox
        cur_req = "R5";
        rset(1, 1, 0, MB_L, 16'hBEEF, 0, 1); step();
        idle(); step(); step();
        cur_req = "R6";
        lset(1, 0, 0, MB_L, '0, 0, 0); step();
        idle(); step();
        rset(1, 1, 0, MB_L, 16'hCAFE, 1, 1); step();
        idle(); lset(1, 0, 1, MB_L, '0, 1, 1); step();
        idle(); step();

        // R7: right mailbox
        cur_req = "R7";
        lset(1, 1, 0, MB_R, 16'h0BAD, 1, 1); step();
        idle(); step();
        rset(1, 0, 1, MB_R, '0, 1, 1); step();
        idle(); step();

        // R8: set and clear together
        cur_req = "R8";
        rset(1, 1, 0, MB_L, 16'h1234, 1, 1);
        lset(1, 0, 1, MB_L, '0, 1, 1); step();
        idle(); step();
        lset(1, 1, 0, MB_R, 16'h4321, 1, 1);
        rset(1, 0, 1, MB_R, '0, 1, 1); step();
        idle(); step();
        lset(1, 0, 1, MB_L, '0, 1, 1); rset(1, 0, 1, MB_R, '0, 1, 1); step();
        idle(); step();

        // R9: own-mailbox writes and peer-mailbox reads
        cur_req = "R9";
        lset(1, 1, 0, MB_L, 16'h5A5A, 1, 1);
        rset(1, 1, 0, MB_R, 16'hA5A5, 1, 1); step();
        lset(1, 0, 1, MB_R, '0, 1, 1);
        rset(1, 0, 1, MB_L, '0, 1, 1); step();
        rset(1, 1, 0, MB_L, 16'h0001, 0, 0); step();          // no lanes: not a write
        idle(); step();

        // R10: disable drops pending and blocks new sets
        cur_req = "R10";
        rset(1, 1, 0, MB_L, 16'h7777, 1, 1);
        lset(1, 1, 0, MB_R, 16'h8888, 1, 1); step();
        idle(); mbox_en = 0; step();
        rset(1, 1, 0, MB_L, 16'h9999, 1, 1);
        lset(1, 1, 0, MB_R, 16'hAAAA, 1, 1); step();
        idle(); step();
        lset(1, 0, 1, MB_L, '0, 1, 1); rset(1, 0, 1, MB_R, '0, 1, 1); step();
        idle(); mbox_en = 1; step(); step();

        // Random mix over a small address set including both mailboxes
        cur_req = "R4";
        for (int i = 0; i < 10; i++) begin
            lset(1, 1, 0, (i < 8) ? AW'(i) : (i == 8 ? MB_L : MB_R), DW'($urandom), 1, 1);
            step();
        end
        for (int i = 0; i < 3000; i++) begin
            int la, ra;
            la = $urandom_range(0, 9);
            ra = $urandom_range(0, 9);
            mbox_en = ($urandom_range(0, 15) != 0);
            lset(1'($urandom), 1'($urandom), 1'($urandom),
                 (la < 8) ? AW'(la) : (la == 8 ? MB_L : MB_R), DW'($urandom),
                 1'($urandom), 1'($urandom));
            rset(1'($urandom), 1'($urandom), 1'($urandom),
                 (ra < 8) ? AW'(ra) : (ra == 8 ? MB_L : MB_R), DW'($urandom),
                 1'($urandom), 1'($urandom));
            step();
        end
        idle(); step();
        finish_run();
    end
endmodule